// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is a second bus master that copies data between addresses without the processor taking part. Firmware sets a start source address, a start destination address, a unit count, a unit width, an increment enable for each side and an operating mode through a small write-only register port. It then sets the enable bit. Each unit is one read followed by one write on a shared bus. The engine asks for that bus with a request/grant handshake and keeps it until both accesses of the unit are finished.

There are three modes. In single-shot mode one unit moves per peripheral trigger, and the engine stops after the last unit. Circular mode differs in two ways: the count reloads and both addresses return to their start values, so the transfer runs until firmware stops it. Copy mode needs no trigger and moves units one after another. Two sticky flags report progress. The half flag marks the midpoint of the programmed units and the done flag marks the end, which supports ping-pong buffer processing.

Top module: `dma_mover`

## Requirements
- R1: Writing the control register (index 3) with bit 0 set while the engine is idle starts a transfer and raises `active`. This happens only when the count register (index 2) is nonzero. With a zero count the engine stays idle and ignores triggers. The other register indices are 0 for the source start address and 1 for the destination start address.
- R2: The width field is control bits 4:3, coded 0 = byte, 1 = half-word, 2 = word. `busSize` carries this code during each access. The unit is right-justified on the data bus, and the write data has every bit above the unit width at zero.
- R3: After each unit, an address whose increment bit is set (control bit 1 for the source, bit 2 for the destination) advances by 1, 2 or 4 bytes according to the width. An address whose increment bit is clear stays fixed.
- R4: Each trigger cycle (`periphReq` high for one clock) moves exactly one unit, which is one read followed by one write of the read data. The count is in units, not bytes.
- R5: A trigger that arrives while a unit is in progress is held pending and served later. This includes triggers on consecutive cycles.
- R6: In single-shot mode (control bits 6:5 = 0), the engine drops `active` and sets `irqDone` after the programmed number of units. Later triggers move nothing.
- R7: In circular mode (bits 6:5 = 1), once the last unit has moved, the count reloads and both addresses return to their start values. `irqDone` is set and `active` stays high.
- R8: `irqHalf` is set when floor(N/2) units of an N-unit run have moved, provided N is at least 2. When N is 1 it never sets.
- R9: In copy mode (bits 6:5 = 2), all units move with no trigger and the engine then goes idle with `irqDone` set.
- R10: `busReq` stays high until `busGnt` arrives. Reads and writes occur only while the grant is held. Each read is followed in the next cycle by its write, and no other access falls between them.
- R11: Both flags are sticky. Writing register index 4 clears `irqHalf` when bit 0 is 1 and clears `irqDone` when bit 1 is 1. Each flag is cleared independently of the other.
- R12: Writing the control register with bit 0 clear stops a running transfer at the next unit boundary. A unit already started completes, and no further units move.
- R13: After reset the engine is idle, with no bus request and both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register index |
| cfgWdata | input | 32 | Register write data |
| periphReq | input | 1 | Peripheral trigger, one unit per high cycle |
| busReq | output | 1 | Bus request |
| busGnt | input | 1 | Bus grant |
| busRd | output | 1 | Read access this cycle |
| busWr | output | 1 | Write access this cycle |
| busAddr | output | 32 | Access address |
| busSize | output | 2 | Access width code |
| busWdata | output | 32 | Write data, right-justified |
| busRdata | input | 32 | Read data, valid in the read cycle |
| active | output | 1 | Transfer running |
| irqHalf | output | 1 | Half-transfer flag |
| irqDone | output | 1 | Transfer-complete flag |

## Verification
The assertions rely on two properties of the bus environment: read data is valid in the same cycle as the read, and the grant, once given, stays up for as long as the request does. The bench arbiter keeps to both. It grants after a programmed wait, holds the grant while the request is high, and drops it only after the request falls. Its memory model returns data that depends on the address, so any misplaced address or missing lane mask shows up in the write data. Width codes, mode codes and counts stay within their defined ranges. The count never exceeds what the pending-trigger counter can hold between units.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {W_BYTE = 2'd0, W_HALF = 2'd1, W_WORD = 2'd2} width_e;
  typedef enum logic [1:0] {M_ONCE = 2'd0, M_RING = 2'd1, M_COPY = 2'd2} mode_e;
  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_REQ, S_RD, S_WR} state_e;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_CTRL = 3'd3;
  localparam logic [2:0] REG_CLR  = 3'd4;

  typedef struct packed {
    logic loadRun;    // copy start values into the running state
    logic latchData;  // capture read data
    logic stepUnit;   // a unit finished: advance or reload
  } dp_strobe_t;
endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              ctlIdle,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] wrData,
  output width_e            width,
  output mode_e             mode,
  output logic              cntZero,
  output logic              lastUnit,
  output logic              halfHit
);
  logic [ADDR_W-1:0] srcBase, dstBase, stepBytes;
  logic [CNT_W-1:0]  cntBase, remain, moved;
  logic              srcInc, dstInc;
  logic [DATA_W-1:0] laneMask;

  // configuration registers; shape fields change only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcBase <= '0;
      dstBase <= '0;
      cntBase <= '0;
      srcInc  <= 1'b0;
      dstInc  <= 1'b0;
      width   <= W_BYTE;
      mode    <= M_ONCE;
    end else if (cfgWe) begin
      case (cfgAddr)
        REG_SRC: srcBase <= cfgWdata[ADDR_W-1:0];
        REG_DST: dstBase <= cfgWdata[ADDR_W-1:0];
        REG_CNT: cntBase <= cfgWdata[CNT_W-1:0];
        REG_CTRL: if (ctlIdle) begin
          srcInc <= cfgWdata[1];
          dstInc <= cfgWdata[2];
          width  <= (cfgWdata[4:3] == 2'b11) ? W_WORD : width_e'(cfgWdata[4:3]);
          mode   <= (cfgWdata[6:5] == 2'b11) ? M_ONCE : mode_e'(cfgWdata[6:5]);
        end
        default: ;
      endcase
    end
  end

  assign stepBytes = ADDR_W'(1) << width;

  always_comb begin
    case (width)
      W_BYTE:  laneMask = DATA_W'(8'hFF);
      W_HALF:  laneMask = DATA_W'(16'hFFFF);
      default: laneMask = '1;
    endcase
  end

  // running addresses and unit counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      remain  <= '0;
      moved   <= '0;
    end else if (strobe.loadRun || (strobe.stepUnit && lastUnit)) begin
      srcAddr <= srcBase;
      dstAddr <= dstBase;
      remain  <= cntBase;
      moved   <= '0;
    end else if (strobe.stepUnit) begin
      srcAddr <= srcAddr + (srcInc ? stepBytes : '0);
      dstAddr <= dstAddr + (dstInc ? stepBytes : '0);
      remain  <= remain - 1'b1;
      moved   <= moved + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wrData <= '0;
    else if (strobe.latchData) wrData <= rdData & laneMask;
  end

  assign cntZero  = (cntBase == '0);
  assign lastUnit = (remain == CNT_W'(1));
  assign halfHit  = (cntBase >= CNT_W'(2)) && ((moved + 1'b1) == (cntBase >> 1));
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int TRIG_W = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       enBit,
  input  logic       clrWr,
  input  logic [1:0] clrBits,
  input  logic       periphReq,
  input  logic       busGnt,
  input  mode_e      mode,
  input  logic       cntZero,
  input  logic       lastUnit,
  input  logic       halfHit,
  output dp_strobe_t strobe,
  output logic       ctlIdle,
  output logic       busReq,
  output logic       busRd,
  output logic       busWr,
  output logic       active,
  output logic       irqHalf,
  output logic       irqDone
);
  state_e            state, nxt;
  logic              stopReq, stopNow, start, trigTake, trigAdd, trigUse;
  logic [TRIG_W-1:0] trigCnt;

  assign start    = ctrlWr && enBit && (state == S_IDLE) && !cntZero;
  assign stopNow  = stopReq || (ctrlWr && !enBit);
  assign trigTake = (state == S_WAIT) && !stopNow && ((mode == M_COPY) || (trigCnt != '0));
  assign trigAdd  = periphReq && (state != S_IDLE) && (mode != M_COPY) && (trigCnt != '1);
  assign trigUse  = trigTake && (mode != M_COPY);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (start) nxt = S_WAIT;
      S_WAIT: if (stopNow) nxt = S_IDLE; else if (trigTake) nxt = S_REQ;
      S_REQ:  if (busGnt) nxt = S_RD;
      S_RD:   nxt = S_WR;
      S_WR:   nxt = (stopNow || (lastUnit && mode != M_RING)) ? S_IDLE : S_WAIT;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stopReq <= 1'b0;
      trigCnt <= '0;
    end else begin
      state <= nxt;
      if (nxt == S_IDLE)         stopReq <= 1'b0;
      else if (ctrlWr && !enBit) stopReq <= 1'b1;
      if (nxt == S_IDLE) trigCnt <= '0;
      else begin
        case ({trigAdd, trigUse})
          2'b10:   trigCnt <= trigCnt + 1'b1;
          2'b01:   trigCnt <= trigCnt - 1'b1;
          default: ;
        endcase
      end
    end
  end

  // sticky flags: setting wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqHalf <= 1'b0;
      irqDone <= 1'b0;
    end else begin
      if (state == S_WR && halfHit)      irqHalf <= 1'b1;
      else if (clrWr && clrBits[0])      irqHalf <= 1'b0;
      if (state == S_WR && lastUnit)     irqDone <= 1'b1;
      else if (clrWr && clrBits[1])      irqDone <= 1'b0;
    end
  end

  assign strobe.loadRun   = start;
  assign strobe.latchData = (state == S_RD);
  assign strobe.stepUnit  = (state == S_WR);
  assign ctlIdle = (state == S_IDLE);
  assign active  = (state != S_IDLE);
  assign busReq  = (state == S_REQ) || (state == S_RD) || (state == S_WR);
  assign busRd   = (state == S_RD);
  assign busWr   = (state == S_WR);
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              periphReq,
  output logic              busReq,
  input  logic              busGnt,
  output logic              busRd,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              active,
  output logic              irqHalf,
  output logic              irqDone
);
  dp_strobe_t        strobe;
  width_e            width;
  mode_e             mode;
  logic              ctlIdle, cntZero, lastUnit, halfHit, ctrlWr, clrWr;
  logic [ADDR_W-1:0] srcAddr, dstAddr;

  assign ctrlWr = cfgWe && (cfgAddr == REG_CTRL);
  assign clrWr  = cfgWe && (cfgAddr == REG_CLR);

  dma_ctrl #(.TRIG_W(TRIG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .enBit(cfgWdata[0]),
    .clrWr(clrWr), .clrBits(cfgWdata[1:0]), .periphReq(periphReq),
    .busGnt(busGnt), .mode(mode), .cntZero(cntZero), .lastUnit(lastUnit),
    .halfHit(halfHit), .strobe(strobe), .ctlIdle(ctlIdle), .busReq(busReq),
    .busRd(busRd), .busWr(busWr), .active(active), .irqHalf(irqHalf),
    .irqDone(irqDone)
  );

  dma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .ctlIdle(ctlIdle), .strobe(strobe),
    .rdData(busRdata), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .wrData(busWdata), .width(width), .mode(mode), .cntZero(cntZero),
    .lastUnit(lastUnit), .halfHit(halfHit)
  );

  assign busAddr = busWr ? dstAddr : srcAddr;
  assign busSize = width;
endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGnt,
  input logic              busRd,
  input logic              busWr,
  input logic [1:0]        busSize,
  input logic [DATA_W-1:0] busWdata,
  input logic              irqHalf,
  input logic              irqDone,
  input logic              clrWr,
  input logic [1:0]        clrBits
);
  AST_ACCESS_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> busGnt); // R10
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> busWr); // R10
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> $past(busRd)); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |=> busReq); // R10
  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSize == 2'd0) |-> (busWdata[DATA_W-1:8] == '0)); // R2
  AST_HALF_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSize == 2'd1) |-> (busWdata[DATA_W-1:16] == '0)); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqDone && !(clrWr && clrBits[1])) |=> irqDone); // R11
  AST_HALF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqHalf && !(clrWr && clrBits[0])) |=> irqHalf); // R11
endmodule

bind dma_mover dma_mover_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busGnt(busGnt), .busRd(busRd),
  .busWr(busWr), .busSize(busSize), .busWdata(busWdata), .irqHalf(irqHalf),
  .irqDone(irqDone), .clrWr(clrWr), .clrBits(cfgWdata[1:0])
);

// File: tb/sim_dma_mover.sv
`timescale 1ns/1ps
module sim_dma_mover;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        periphReq = 1'b0;
  logic        busReq, busRd, busWr, active, irqHalf, irqDone;
  logic        busGnt = 1'b0;
  logic [31:0] busAddr, busWdata, busRdata;
  logic [1:0]  busSize;

  int checks = 0, errors = 0;
  int wrCnt = 0, rdCnt = 0, dataErr = 0, sizeErr = 0, hsErr = 0;
  int gntDelay = 0, waitCnt = 0;
  logic [31:0] lastRd = '0, lastWr = '0;
  logic [1:0]  curWidth = '0;
  bit          finished = 0;

  always #4 clk = ~clk;

  dma_mover u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .periphReq(periphReq), .busReq(busReq), .busGnt(busGnt), .busRd(busRd),
    .busWr(busWr), .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .active(active), .irqHalf(irqHalf), .irqDone(irqDone)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction
  function automatic logic [31:0] laneMask(input logic [1:0] w);
    return (w == 2'd0) ? 32'hFF : (w == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign busRdata = pat(busAddr);

  // arbiter: grant after gntDelay waiting cycles, hold while requested
  always @(negedge clk) begin
    if (!busReq) begin waitCnt <= 0; busGnt <= 1'b0; end
    else if (waitCnt >= gntDelay) busGnt <= 1'b1;
    else waitCnt <= waitCnt + 1;
  end

  // bus monitor
  always @(negedge clk) if (rstN) begin
    if ((busRd || busWr) && !busGnt) hsErr++;
    if (busRd) begin rdCnt++; lastRd = busAddr; end
    if (busWr) begin
      wrCnt++; lastWr = busAddr;
      if (busWdata !== (pat(lastRd) & laneMask(busSize))) dataErr++;
      if (busSize !== curWidth) sizeErr++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk); cfgWe = 1'b0; cfgWdata = '0;
  endtask

  task automatic trig(input int n);
    @(negedge clk); periphReq = 1'b1;
    repeat (n) @(negedge clk);
    periphReq = 1'b0;
  endtask

  task automatic waitIdle(input int maxCyc);
    for (int i = 0; i < maxCyc && active; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] ctrlWord(input logic [1:0] m, input logic [1:0] w,
                                           input logic di, input logic si, input logic en);
    return {25'd0, m, w, di, si, en};
  endfunction

  function automatic void clearLog(input logic [1:0] w);
    wrCnt = 0; rdCnt = 0; dataErr = 0; sizeErr = 0; hsErr = 0; curWidth = w;
  endfunction

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  width;
    logic        srcInc;
    logic        dstInc;
    logic [15:0] cnt;
    logic [31:0] src;
    logic [31:0] dst;
    logic [7:0]  trigs;
    logic [7:0]  expWr;
    logic [31:0] expSrc;
    logic [31:0] expDst;
    logic        expHalf;
    logic        expDone;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 1'b1, 1'b1, 16'd4, 32'h100,  32'h200,  8'd4, 8'd4, 32'h103,  32'h203,  1'b1, 1'b1},
    '{2'd0, 2'd1, 1'b1, 1'b0, 16'd3, 32'h300,  32'h40,   8'd3, 8'd3, 32'h304,  32'h40,   1'b1, 1'b1},
    '{2'd0, 2'd2, 1'b1, 1'b1, 16'd2, 32'h1000, 32'h2000, 8'd2, 8'd2, 32'h1004, 32'h2004, 1'b1, 1'b1},
    '{2'd2, 2'd2, 1'b1, 1'b1, 16'd5, 32'h400,  32'h800,  8'd0, 8'd5, 32'h410,  32'h810,  1'b1, 1'b1},
    '{2'd2, 2'd1, 1'b0, 1'b1, 16'd4, 32'h20,   32'h600,  8'd0, 8'd4, 32'h20,   32'h606,  1'b1, 1'b1},
    '{2'd1, 2'd0, 1'b1, 1'b1, 16'd3, 32'h10,   32'h50,   8'd5, 8'd5, 32'h11,   32'h51,   1'b1, 1'b1},
    '{2'd0, 2'd0, 1'b1, 1'b1, 16'd1, 32'h7,    32'h9,    8'd1, 8'd1, 32'h7,    32'h9,    1'b0, 1'b1},
    '{2'd1, 2'd2, 1'b1, 1'b1, 16'd2, 32'h80,   32'hC0,   8'd3, 8'd3, 32'h80,   32'hC0,   1'b1, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(active == 1'b0, "R13 active", active, 0);
    chk(busReq == 1'b0, "R13 busReq", busReq, 0);
    chk(irqHalf == 1'b0 && irqDone == 1'b0, "R13 flags", {irqHalf, irqDone}, 0);

    for (int v = 0; v < NVEC; v++) begin
      vec_t t = VECS[v];
      gntDelay = v % 3;
      regWr(3'd4, 32'h3);
      chk({irqHalf, irqDone} == 2'b00, "R11 clear both", {irqHalf, irqDone}, 0);
      regWr(3'd0, t.src);
      regWr(3'd1, t.dst);
      regWr(3'd2, {16'd0, t.cnt});
      clearLog(t.width);
      regWr(3'd3, ctrlWord(t.mode, t.width, t.dstInc, t.srcInc, 1'b1));
      chk(active == 1'b1, "R1 start", active, 1);
      for (int k = 0; k < int'(t.trigs); k++) begin
        trig(1);
        repeat (10) @(negedge clk);
      end
      if (t.mode == 2'd1) begin
        repeat (20) @(negedge clk);
        chk(active == 1'b1, "R7 ring keeps running", active, 1);
        regWr(3'd3, ctrlWord(t.mode, t.width, t.dstInc, t.srcInc, 1'b0));
        repeat (4) @(negedge clk);
        chk(active == 1'b0, "R12 ring stopped", active, 0);
      end else begin
        waitIdle(300);
        chk(active == 1'b0, (t.mode == 2'd2) ? "R9 copy finished" : "R6 once finished", active, 0);
      end
      chk(wrCnt == int'(t.expWr), "R4 unit count", wrCnt, t.expWr);
      chk(rdCnt == wrCnt, "R4 read per write", rdCnt, wrCnt);
      chk(lastRd == t.expSrc, "R3 last source", lastRd, t.expSrc);
      chk(lastWr == t.expDst, (t.mode == 2'd1) ? "R7 ring wrap" : "R3 last dest", lastWr, t.expDst);
      chk(irqHalf == t.expHalf, "R8 half flag", irqHalf, t.expHalf);
      chk(irqDone == t.expDone, "R6 done flag", irqDone, t.expDone);
      chk(dataErr == 0, "R2 data lanes", dataErr, 0);
      chk(sizeErr == 0, "R2 size code", sizeErr, 0);
      chk(hsErr == 0, "R10 access under grant", hsErr, 0);
    end

    // R1: zero count does not start
    regWr(3'd4, 32'h3);
    regWr(3'd2, 32'd0);
    clearLog(2'd0);
    regWr(3'd3, ctrlWord(2'd0, 2'd0, 1'b1, 1'b1, 1'b1));
    chk(active == 1'b0, "R1 zero count idle", active, 0);
    trig(2); repeat (10) @(negedge clk);
    chk(wrCnt == 0, "R1 zero count no moves", wrCnt, 0);

    // R5: back-to-back triggers with slow grant are all served
    gntDelay = 4;
    regWr(3'd0, 32'h900); regWr(3'd1, 32'hA00); regWr(3'd2, 32'd3);
    clearLog(2'd0);
    regWr(3'd3, ctrlWord(2'd0, 2'd0, 1'b1, 1'b1, 1'b1));
    trig(3);
    waitIdle(300);
    chk(wrCnt == 3, "R5 pending triggers served", wrCnt, 3);
    chk(lastWr == 32'hA02, "R5 last dest", lastWr, 32'hA02);
    chk(hsErr == 0, "R10 slow grant", hsErr, 0);
    chk(irqDone == 1'b1, "R6 done after burst", irqDone, 1);
    // R6: triggers after completion move nothing
    trig(2); repeat (10) @(negedge clk);
    chk(wrCnt == 3, "R6 idle ignores triggers", wrCnt, 3);
    // R11: independent clears
    regWr(3'd4, 32'h2);
    chk(irqDone == 1'b0, "R11 done cleared", irqDone, 0);
    chk(irqHalf == 1'b1, "R11 half kept", irqHalf, 1);
    regWr(3'd4, 32'h1);
    chk(irqHalf == 1'b0, "R11 half cleared", irqHalf, 0);

    // R12: stop between units
    gntDelay = 0;
    regWr(3'd2, 32'd4);
    clearLog(2'd0);
    regWr(3'd3, ctrlWord(2'd0, 2'd0, 1'b1, 1'b1, 1'b1));
    trig(1); repeat (10) @(negedge clk);
    regWr(3'd3, ctrlWord(2'd0, 2'd0, 1'b1, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    chk(active == 1'b0, "R12 stopped", active, 0);
    trig(2); repeat (10) @(negedge clk);
    chk(wrCnt == 1, "R12 no units after stop", wrCnt, 1);

    // R12: stop during a copy run finishes the current unit only
    regWr(3'd2, 32'd50);
    clearLog(2'd2);
    regWr(3'd3, ctrlWord(2'd2, 2'd2, 1'b1, 1'b1, 1'b1));
    repeat (7) @(negedge clk);
    regWr(3'd3, ctrlWord(2'd2, 2'd2, 1'b1, 1'b1, 1'b0));
    waitIdle(50);
    chk(active == 1'b0, "R12 copy stopped", active, 0);
    chk(wrCnt > 0 && wrCnt < 50, "R12 partial copy", wrCnt, 50);
    chk(rdCnt == wrCnt, "R12 unit completed", rdCnt, wrCnt);
    chk(irqDone == 1'b0, "R12 no done on stop", irqDone, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule